// File: doc/BRIEF.md
# Parallel-Channel Pattern Source and Response Compactor

This block sits at the ends of a set of parallel scan channels during logic self-test. On one side, a 61-stage linear-feedback shift register produces a new pseudorandom word on every shift cycle. Each bit of that word is XORed with stage 0 before it drives its channel's scan input. This breaks the one-cycle lag that would otherwise tie each channel to its neighbour. On the other side, a 61-stage multiple-input signature register absorbs all 61 channel scan outputs on every shift cycle.

A sequencer outside this block first loads both registers with seeds. It then raises the shift enable for as many cycles as the test needs. At the end it compares the resulting signature against the expected value that it presents on an input. The block reports that comparison on a registered pass flag. Both registers use the same feedback polynomial, with taps at stages 0, 14, 15 and 60. Data moves toward stage 0, and the feedback parity enters at stage 60.

Top module: `stumps_pattern_sig`

## Requirements
- R1: While `rst` is high at a clock edge, the generator becomes 1 (only stage 0 set), the signature becomes all zeros and `sig_pass` becomes 0.
- R2: When `seed_load` is high at a clock edge, the generator takes `gen_seed` and the signature takes `sig_seed`, whatever the state of `shift_en`.
- R3: When `shift_en` is high and `seed_load` is low, the generator steps: new stage i = old stage i+1 for i = 0..59, and new stage 60 = XOR of old stages 0, 14, 15 and 60. An all-zero generator stays all zero.
- R4: When both `shift_en` and `seed_load` are low, neither the generator nor the signature changes, whatever `resp_in` carries.
- R5: `chan_out[i]` equals generator stage i XOR generator stage 0 for every i, in the same cycle as the generator value; `chan_out[0]` is therefore always 0.
- R6: When `shift_en` is high and `seed_load` is low, the signature steps: new bit i = old bit i+1 XOR `resp_in[i]` for i = 0..59, and new bit 60 = XOR of old bits 0, 14, 15, 60 and `resp_in[60]`.
- R7: After every clock edge with `rst` low, `sig_pass` is 1 exactly when the value `signature` now holds equals the `expect_sig` that was present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load both registers from the seed inputs |
| shift_en | input | 1 | Step both registers by one shift cycle |
| gen_seed | input | 61 | Seed for the pattern generator |
| sig_seed | input | 61 | Seed for the signature register |
| resp_in | input | 61 | Scan outputs of the 61 channels |
| expect_sig | input | 61 | Expected signature to compare against |
| chan_out | output | 61 | Spread pattern bits driving the channel scan inputs |
| signature | output | 61 | Current signature register contents |
| sig_pass | output | 1 | Registered result of the signature comparison |

## Verification
Long shift runs with random channel responses exercise both polynomials together. Any tap or direction error then shows up in the spread channel word and in the signature within a few cycles. Hold cycles are run with responses that keep changing, which shows that a disabled register really ignores its data inputs. An all-zero response stream turns the compactor into a free-running LFSR, so its feedback can be checked on its own, without the data XOR. An all-zero generator seed confirms that the generator locks at zero. A load issued together with the shift enable confirms that the load wins. Expected-signature inputs alternate between the exact upcoming value and a value off by one word, so the pass flag must switch both ways and line up with the signature it is meant to reflect.

// File: rtl/stumps_pkg.sv
package stumps_pkg;
  localparam int unsigned CHAN_W = 61;
  // Feedback stages 0, 14, 15 and 60
  localparam logic [CHAN_W-1:0] POLY_TAPS = 61'h1000_0000_0000_C001;
  localparam logic [CHAN_W-1:0] GEN_RESET = {{(CHAN_W-1){1'b0}}, 1'b1};
endpackage

// File: rtl/prpg_core.sv
module prpg_core #(
  parameter int unsigned W = stumps_pkg::CHAN_W,
  parameter logic [W-1:0] TAPS = stumps_pkg::POLY_TAPS,
  parameter logic [W-1:0] INIT = stumps_pkg::GEN_RESET
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_step;
  logic         fb;

  assign fb      = ^(st_q & TAPS);
  assign st_step = {fb, st_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)       st_q <= INIT;
    else if (load) st_q <= seed;
    else if (step) st_q <= st_step;
  end

  assign state = st_q;
endmodule

// File: rtl/phase_spreader.sv
module phase_spreader #(
  parameter int unsigned W = stumps_pkg::CHAN_W
) (
  input  logic [W-1:0] gen,
  output logic [W-1:0] chan
);
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign chan[i] = gen[i] ^ gen[0];
  end
endmodule

// File: rtl/misr_core.sv
module misr_core #(
  parameter int unsigned W = stumps_pkg::CHAN_W,
  parameter logic [W-1:0] TAPS = stumps_pkg::POLY_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] resp,
  output logic [W-1:0] state,
  output logic [W-1:0] state_d
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_step;

  for (genvar i = 0; i < W - 1; i++) begin : g_stage
    assign st_step[i] = st_q[i+1] ^ resp[i];
  end
  assign st_step[W-1] = (^(st_q & TAPS)) ^ resp[W-1];

  always_comb begin
    if (load)      state_d = seed;
    else if (step) state_d = st_step;
    else           state_d = st_q;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= state_d;
  end

  assign state = st_q;
endmodule

// File: rtl/sig_compare.sv
module sig_compare #(
  parameter int unsigned W = stumps_pkg::CHAN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cand,
  input  logic [W-1:0] golden,
  output logic         match
);
  logic match_q;

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= (cand == golden);
  end

  assign match = match_q;
endmodule

// File: rtl/stumps_pattern_sig.sv
module stumps_pattern_sig #(
  parameter int unsigned W = stumps_pkg::CHAN_W,
  parameter logic [W-1:0] TAPS = stumps_pkg::POLY_TAPS,
  parameter logic [W-1:0] GEN_INIT = stumps_pkg::GEN_RESET
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_load,
  input  logic         shift_en,
  input  logic [W-1:0] gen_seed,
  input  logic [W-1:0] sig_seed,
  input  logic [W-1:0] resp_in,
  input  logic [W-1:0] expect_sig,
  output logic [W-1:0] chan_out,
  output logic [W-1:0] signature,
  output logic         sig_pass
);
  logic [W-1:0] gen_state;
  logic [W-1:0] sig_state;
  logic [W-1:0] sig_d;

  prpg_core #(.W(W), .TAPS(TAPS), .INIT(GEN_INIT)) u_prpg (
    .clk   (clk),
    .rst   (rst),
    .load  (seed_load),
    .step  (shift_en),
    .seed  (gen_seed),
    .state (gen_state)
  );

  phase_spreader #(.W(W)) u_spread (
    .gen  (gen_state),
    .chan (chan_out)
  );

  misr_core #(.W(W), .TAPS(TAPS)) u_misr (
    .clk     (clk),
    .rst     (rst),
    .load    (seed_load),
    .step    (shift_en),
    .seed    (sig_seed),
    .resp    (resp_in),
    .state   (sig_state),
    .state_d (sig_d)
  );

  sig_compare #(.W(W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .cand   (sig_d),
    .golden (expect_sig),
    .match  (sig_pass)
  );

  assign signature = sig_state;
endmodule

// File: rtl/stumps_pattern_sig_chk.sv
module stumps_pattern_sig_chk #(
  parameter int unsigned W = stumps_pkg::CHAN_W
) (
  input logic         clk,
  input logic         rst,
  input logic         seed_load,
  input logic         shift_en,
  input logic [W-1:0] gen_seed,
  input logic [W-1:0] sig_seed,
  input logic [W-1:0] resp_in,
  input logic [W-1:0] expect_sig,
  input logic [W-1:0] gen,
  input logic [W-1:0] chan_out,
  input logic [W-1:0] signature,
  input logic         sig_pass
);
  // R2: seeds land one edge after a load
  a_r2_seed_load: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (gen == $past(gen_seed)) && (signature == $past(sig_seed)));

  // R3: generator shifts toward stage 0
  a_r3_gen_shift: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !seed_load) |=> gen[W-2:0] == $past(gen[W-1:1]));

  // R4: both registers hold when idle
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !seed_load) |=> $stable(gen) && $stable(signature));

  // R5: stage-0 channel is always quiet
  a_r5_chan0_zero: assert property (@(posedge clk) disable iff (rst)
    chan_out[0] == 1'b0);

  // R6: signature absorbs responses while shifting
  a_r6_sig_shift: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !seed_load) |=>
      signature[W-2:0] == ($past(signature[W-1:1]) ^ $past(resp_in[W-2:0])));

  // R7: pass flag matches the signature it accompanies
  a_r7_pass: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sig_pass == (signature == $past(expect_sig)));
endmodule

bind stumps_pattern_sig stumps_pattern_sig_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .seed_load  (seed_load),
  .shift_en   (shift_en),
  .gen_seed   (gen_seed),
  .sig_seed   (sig_seed),
  .resp_in    (resp_in),
  .expect_sig (expect_sig),
  .gen        (gen_state),
  .chan_out   (chan_out),
  .signature  (signature),
  .sig_pass   (sig_pass)
);

// File: tb/sim_stumps_pattern_sig.sv
module sim_stumps_pattern_sig;
  localparam int N = 61;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         seed_load = 1'b0;
  logic         shift_en = 1'b0;
  logic [N-1:0] gen_seed = '0;
  logic [N-1:0] sig_seed = '0;
  logic [N-1:0] resp_in = '0;
  logic [N-1:0] expect_sig = '0;
  logic [N-1:0] chan_out;
  logic [N-1:0] signature;
  logic         sig_pass;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_gen;
  logic [N-1:0] m_sig;
  logic         m_pass;

  always #10 clk = ~clk;

  stumps_pattern_sig u0 (
    .clk        (clk),
    .rst        (rst),
    .seed_load  (seed_load),
    .shift_en   (shift_en),
    .gen_seed   (gen_seed),
    .sig_seed   (sig_seed),
    .resp_in    (resp_in),
    .expect_sig (expect_sig),
    .chan_out   (chan_out),
    .signature  (signature),
    .sig_pass   (sig_pass)
  );

  function automatic logic [N-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[N-1:0];
  endfunction

  function automatic logic [N-1:0] gen_next(input logic [N-1:0] g);
    logic [N-1:0] r;
    for (int i = 0; i < N - 1; i++) r[i] = g[i+1];
    r[N-1] = g[0] ^ g[14] ^ g[15] ^ g[60];
    return r;
  endfunction

  function automatic logic [N-1:0] sig_next(input logic [N-1:0] s, input logic [N-1:0] d);
    logic [N-1:0] r;
    for (int i = 0; i < N - 1; i++) r[i] = s[i+1] ^ d[i];
    r[N-1] = s[0] ^ s[14] ^ s[15] ^ s[60] ^ d[60];
    return r;
  endfunction

  function automatic logic [N-1:0] spread(input logic [N-1:0] g);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = g[i] ^ g[0];
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tg, input string ts);
    check({tg, "/R5"}, "chan_out", chan_out, spread(m_gen));
    check(ts, "signature", signature, m_sig);
    check("R7", "sig_pass", {{(N-1){1'b0}}, sig_pass}, {{(N-1){1'b0}}, m_pass});
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge.
  task automatic step(input logic ld, input logic en, input logic [N-1:0] gs,
                      input logic [N-1:0] ss, input logic [N-1:0] rs,
                      input bit want_match, input string tg, input string ts);
    logic [N-1:0] g_n;
    logic [N-1:0] s_n;
    logic [N-1:0] ex;
    if (ld) begin
      g_n = gs; s_n = ss;
    end else if (en) begin
      g_n = gen_next(m_gen); s_n = sig_next(m_sig, rs);
    end else begin
      g_n = m_gen; s_n = m_sig;
    end
    ex = want_match ? s_n : (s_n ^ {{(N-1){1'b0}}, 1'b1});
    seed_load = ld; shift_en = en; gen_seed = gs; sig_seed = ss;
    resp_in = rs; expect_sig = ex;
    @(posedge clk);
    @(negedge clk);
    m_gen = g_n; m_sig = s_n; m_pass = (s_n == ex);
    compare_all(tg, ts);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    m_gen = {{(N-1){1'b0}}, 1'b1}; m_sig = '0; m_pass = 1'b0;
    compare_all("R1", "R1");
    rst = 1'b0;

    // R2: plain seed load
    step(1'b1, 1'b0, 61'h0ABC_DEF0_1234_5678, 61'h1357_9BDF_0246_8ACE, rnd(), 1'b0, "R2", "R2");

    // R3/R6: long random shift run, pass alternating
    for (int k = 0; k < 60; k++)
      step(1'b0, 1'b1, rnd(), rnd(), rnd(), (k % 3) == 0, "R3", "R6");

    // R4: hold with changing responses and seeds
    for (int k = 0; k < 12; k++)
      step(1'b0, 1'b0, rnd(), rnd(), rnd(), k[0], "R4", "R4");

    // R2: load wins over shift enable
    step(1'b1, 1'b1, rnd(), rnd(), rnd(), 1'b1, "R2", "R2");

    // R6: zero responses, compactor runs free
    for (int k = 0; k < 30; k++)
      step(1'b0, 1'b1, rnd(), rnd(), '0, k[0], "R3", "R6");

    // R3: all-zero generator locks at zero
    step(1'b1, 1'b0, '0, rnd(), rnd(), 1'b1, "R2", "R2");
    for (int k = 0; k < 8; k++)
      step(1'b0, 1'b1, rnd(), rnd(), rnd(), 1'b0, "R3", "R6");

    // R7: final signature compare after a clean seeded run
    step(1'b1, 1'b0, 61'h1FFF_FFFF_FFFF_FFFF, '0, '0, 1'b0, "R2", "R2");
    for (int k = 0; k < 40; k++)
      step(1'b0, 1'b1, rnd(), rnd(), rnd(), k == 39, "R3", "R6");
    step(1'b0, 1'b0, rnd(), rnd(), rnd(), 1'b1, "R4", "R4");

    // R1: reset again from a busy state
    rst = 1'b1; shift_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_gen = {{(N-1){1'b0}}, 1'b1}; m_sig = '0; m_pass = 1'b0;
    compare_all("R1", "R1");
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..R7 run incomplete): actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule